// File: doc/BRIEF.md
# Power-Down and Wake Controller

This block decides whether an Ethernet MAC function is powered down. It holds a power-down request bit that software sets, a second power-down bit kept in an auxiliary register, and a third power-down source that arrives as an input from elsewhere on the chip. The function counts as powered down while any one of the three sources is active. The request bit is one-shot in nature: any register write from the host clears it, whatever the address, unless the write is a control-register write that sets it again.

A pulse from the receive path reports that a wake-up frame has been recognised. Frame recognition is done outside this block. When wake-up is enabled, the pulse clears both register-held power-down bits, so the function returns to full power (unless the external source still holds it down). The pulse also sets a sticky wake-up flag. When interrupts are enabled, the flag drives the interrupt output. When wake-up is disabled, the pulse is ignored completely. Reset is synchronous and active low, and every register bit resets to 0.

Register map, chosen by `host_wr_addr` and using `host_wr_data` bits 1:0:
- Control, offset 0: bit0 is the power-down request and bit1 is the wake-up enable.
- Auxiliary, offset 1: bit0 is the auxiliary power-down bit and bit1 is the interrupt enable.
- Acknowledge, offset 2: writing with bit0 = 1 clears the wake-up flag.

Every other offset holds no state, but a write there still counts as a host write.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, the request bit, the wake-up enable, the auxiliary bit, the interrupt enable and the wake flag are all 0. `pd_out` then equals `ext_pd_in` and `irq_out` is 0.
- R2: A write to offset 0 loads `host_wr_data[0]` into the request bit and `host_wr_data[1]` into the wake-up enable. Both values are visible from the following cycle.
- R3: A write to any offset other than 0 clears the request bit on the next cycle. The wake-up enable keeps its value through that clear.
- R4: A write to offset 1 loads the auxiliary bit from data bit0 and the interrupt enable from data bit1. Writes to other offsets leave both unchanged.
- R5: `pd_out` is high exactly when the request bit, the auxiliary bit or `ext_pd_in` is high.
- R6: A `wake_pulse` while the wake-up enable is 1 clears the request bit and the auxiliary bit on the next cycle. This takes priority over a host write in the same cycle that would set either bit.
- R7: A `wake_pulse` while the wake-up enable is 1 sets the wake flag on the next cycle. Nothing else sets the flag.
- R8: A `wake_pulse` while the wake-up enable is 0 has no effect on the power-down bits or on the flag.
- R9: The wake flag stays set until a write to offset 2 with data bit0 = 1 clears it. A write to offset 2 with bit0 = 0 leaves it set. If a wake-up event and a clearing write happen in the same cycle, the flag stays set.
- R10: `irq_out` is high exactly when the wake flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| host_wr_en | input | 1 | Host register write strobe, one cycle per write |
| host_wr_addr | input | ADDR_W (4) | Register offset of the write |
| host_wr_data | input | DATA_W (2) | Write data bits used by the registers |
| wake_pulse | input | 1 | One-cycle report of a recognised wake-up frame |
| ext_pd_in | input | 1 | Third power-down source |
| pd_out | output | 1 | Function is powered down |
| wake_flag | output | 1 | Sticky wake-up status |
| irq_out | output | 1 | Wake-up interrupt request |

## Verification
The bound checker watches, on every cycle, these properties:
- the control-register load and the clear by writes to other offsets;
- that an enabled wake-up event drops both register-held power-down bits and sets the flag;
- that a disabled pulse changes nothing;
- that the flag is sticky and is set from no other cause;
- that the OR on `pd_out` and the interrupt gating hold.

Only the bench scenarios can show the remaining points. These are the full value sequences through multi-step programs, and the wake-up enable surviving the self-clear and being used several writes later. They also cover the collision cases (a wake-up against a setting write, and against an acknowledge) and a mid-run reset with the external source both high and low.

// File: rtl/pwr_pkg.sv
// Package: shared register offsets and bit positions for the power-down
// and wake controller. Assumes host data carries at least two bits.
package pwr_pkg;
    localparam int CTRL_OFS    = 0;  // request bit + wake-up enable
    localparam int AUX_OFS     = 1;  // auxiliary power-down + irq enable
    localparam int ACK_OFS     = 2;  // flag acknowledge
    localparam int PD_BIT      = 0;
    localparam int WEN_BIT     = 1;
    localparam int AUXPD_BIT   = 0;
    localparam int IEN_BIT     = 1;
    localparam int ACK_BIT     = 0;
    localparam int NUM_PD_SRC  = 3;

    typedef struct packed {
        logic pd_req;
        logic wake_en;
        logic aux_pd;
        logic irq_en;
    } pwr_cfg_t;
endpackage

// File: rtl/pwr_ctrl_regs.sv
// Module: pwr_ctrl_regs
// Holds the control and auxiliary register bits. The request bit clears
// on any host write that is not a control write. An enabled wake-up event
// clears both power-down bits and wins over a same-cycle host write.
// Assumes host writes are single-cycle strobes.
module pwr_ctrl_regs
    import pwr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake_hit,
    output pwr_cfg_t          cfg
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] AUX_A  = ADDR_W'(AUX_OFS);

    pwr_cfg_t cfg_q;
    logic     ctrl_wr;
    logic     aux_wr;

    // Purpose: decode which register the current write addresses.
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == CTRL_A);
        aux_wr  = wr_en && (wr_addr == AUX_A);
    end

    // Purpose: update the request bit and wake-up enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.pd_req  <= 1'b0;
            cfg_q.wake_en <= 1'b0;
        end else begin
            if (ctrl_wr)
                cfg_q.wake_en <= wr_data[WEN_BIT];
            if (wake_hit)
                cfg_q.pd_req <= 1'b0;
            else if (ctrl_wr)
                cfg_q.pd_req <= wr_data[PD_BIT];
            else if (wr_en)
                cfg_q.pd_req <= 1'b0;
        end
    end

    // Purpose: update the auxiliary power-down bit and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.aux_pd <= 1'b0;
            cfg_q.irq_en <= 1'b0;
        end else begin
            if (aux_wr)
                cfg_q.irq_en <= wr_data[IEN_BIT];
            if (wake_hit)
                cfg_q.aux_pd <= 1'b0;
            else if (aux_wr)
                cfg_q.aux_pd <= wr_data[AUXPD_BIT];
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pwr_wake_status.sv
// Module: pwr_wake_status
// Sticky wake-up flag and its interrupt gate. A wake-up event sets the
// flag and wins over an acknowledge in the same cycle.
module pwr_wake_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_hit,
    input  logic ack,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic flag_q;

    // Purpose: set on wake-up, clear on acknowledge, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (wake_hit)
            flag_q <= 1'b1;
        else if (ack)
            flag_q <= 1'b0;
    end

    // Purpose: gate the flag onto the interrupt line.
    always_comb irq = flag_q && irq_en;

    assign flag = flag_q;
endmodule

// File: rtl/pwr_pd_combine.sv
// Module: pwr_pd_combine
// OR of an arbitrary number of power-down sources. The chain is built by
// a generate loop so that the source count can grow.
module pwr_pd_combine #(
    parameter int NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] src,
    output logic               pd
);
    logic [NUM_SRC:0] chain;

    assign chain[0] = 1'b0;
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_or
        assign chain[g+1] = chain[g] | src[g];
    end

    assign pd = chain[NUM_SRC];
endmodule

// File: rtl/pwr_wake_ctrl.sv
// Module: pwr_wake_ctrl (top)
// Power-down decision and wake-up handling for a MAC function. It combines
// a self-clearing request bit, an auxiliary bit and an external source
// into pd_out, and turns enabled wake-up pulses into a sticky flag and an
// interrupt. Assumes wake_pulse is synchronous to clk.
module pwr_wake_ctrl
    import pwr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              wake_pulse,
    input  logic              ext_pd_in,
    output logic              pd_out,
    output logic              wake_flag,
    output logic              irq_out
);
    localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(ACK_OFS);

    pwr_cfg_t              cfg;
    logic                  wake_hit;
    logic                  ack_wr;
    logic [NUM_PD_SRC-1:0] pd_src;

    // Purpose: qualify the wake pulse and decode the acknowledge write.
    always_comb begin
        wake_hit = wake_pulse && cfg.wake_en;
        ack_wr   = host_wr_en && (host_wr_addr == ACK_A) && host_wr_data[ACK_BIT];
        pd_src   = {ext_pd_in, cfg.aux_pd, cfg.pd_req};
    end

    pwr_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr_en),
        .wr_addr  (host_wr_addr),
        .wr_data  (host_wr_data),
        .wake_hit (wake_hit),
        .cfg      (cfg)
    );

    pwr_wake_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_hit (wake_hit),
        .ack      (ack_wr),
        .irq_en   (cfg.irq_en),
        .flag     (wake_flag),
        .irq      (irq_out)
    );

    pwr_pd_combine #(.NUM_SRC(NUM_PD_SRC)) u_comb (
        .src (pd_src),
        .pd  (pd_out)
    );
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
// Module: pwr_wake_ctrl_chk
// Cycle-by-cycle properties of the controller, bound into the top module.
module pwr_wake_ctrl_chk
    import pwr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr_en,
    input logic [ADDR_W-1:0] host_wr_addr,
    input logic [DATA_W-1:0] host_wr_data,
    input logic              wake_pulse,
    input logic              ext_pd_in,
    input logic              pd_out,
    input logic              wake_flag,
    input logic              irq_out,
    input pwr_cfg_t          cfg
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_OFS);

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en && host_wr_addr == CTRL_A && !(wake_pulse && cfg.wake_en)
        |=> cfg.pd_req == $past(host_wr_data[PD_BIT]) && cfg.wake_en == $past(host_wr_data[WEN_BIT])); // R2

    AST_OTHER_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en && host_wr_addr != CTRL_A |=> !cfg.pd_req && cfg.wake_en == $past(cfg.wake_en)); // R3

    AST_PD_OR: assert property (@(posedge clk) disable iff (!rst_n)
        pd_out == (cfg.pd_req || cfg.aux_pd || ext_pd_in)); // R5

    AST_WAKE_POWERS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse && cfg.wake_en |=> !cfg.pd_req && !cfg.aux_pd); // R6

    AST_WAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse && cfg.wake_en |=> wake_flag); // R7

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(wake_pulse && cfg.wake_en)); // R7

    AST_PULSE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse && !cfg.wake_en && !host_wr_en
        |=> $stable(cfg.pd_req) && $stable(cfg.aux_pd) && $stable(wake_flag)); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wake_flag && !(host_wr_en && host_wr_addr == ACK_A && host_wr_data[ACK_BIT]) |=> wake_flag); // R9

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (wake_flag && cfg.irq_en)); // R10
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_wr_addr (host_wr_addr),
    .host_wr_data (host_wr_data),
    .wake_pulse   (wake_pulse),
    .ext_pd_in    (ext_pd_in),
    .pd_out       (pd_out),
    .wake_flag    (wake_flag),
    .irq_out      (irq_out),
    .cfg          (cfg)
);

// File: tb/sim_pwr_wake_ctrl.sv
// Bench for pwr_wake_ctrl: a vector table walked by one loop, then
// directed reset and idle checks.
module sim_pwr_wake_ctrl;
    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [1:0] data;
        logic       pulse;
        logic       ext;
        logic       pd;
        logic       flag;
        logic       irq;
    } vec_t;

    localparam int NV = 21;
    // Expected outputs are those one clock after the vector is applied.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // 0  R2 set request
        '{1'b1, 4'd3, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 1  R3 stray write clears
        '{1'b1, 4'd0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // 2  R2 request + wake enable
        '{1'b0, 4'd0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // 3  R5 ext high too
        '{1'b1, 4'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 4  R3 R4 aux write clears request
        '{1'b1, 4'd1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // 5  R4 aux pd + irq enable
        '{1'b0, 4'd0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // 6  R5 aux alone holds pd
        '{1'b0, 4'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // 7  R3 R6 R7 R10 enable kept, wake
        '{1'b1, 4'd0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // 8  R9 flag sticky, wake off
        '{1'b0, 4'd0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // 9  R8 pulse ignored
        '{1'b1, 4'd2, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 10 R9 ack clears, R3 pd clears
        '{1'b0, 4'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // 11 R8 no flag
        '{1'b1, 4'd0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // 12 R2
        '{1'b1, 4'd0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // 13 R6 wake beats setting write
        '{1'b1, 4'd2, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // 14 R9 set beats ack
        '{1'b1, 4'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // 15 R10 irq disabled
        '{1'b1, 4'd2, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // 16 R9 bit0=0 keeps flag
        '{1'b1, 4'd2, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 17 R9 ack
        '{1'b0, 4'd0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // 18 R5 ext only
        '{1'b1, 4'd0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // 19 R2 wake off
        '{1'b0, 4'd0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}  // 20 R8 pd held
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [3:0] host_wr_addr = '0;
    logic [1:0] host_wr_data = '0;
    logic       wake_pulse = 1'b0;
    logic       ext_pd_in = 1'b0;
    logic       pd_out, wake_flag, irq_out;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    pwr_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en),
        .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .wake_pulse(wake_pulse), .ext_pd_in(ext_pd_in),
        .pd_out(pd_out), .wake_flag(wake_flag), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {pd,flag,irq} got %b expected %b", req, got, exp);
        end
    endtask

    task automatic idle();
        host_wr_en = 1'b0; host_wr_addr = '0; host_wr_data = '0; wake_pulse = 1'b0;
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        check("R1 reset state", {pd_out, wake_flag, irq_out}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            host_wr_en   = VEC[i].wr;
            host_wr_addr = VEC[i].addr;
            host_wr_data = VEC[i].data;
            wake_pulse   = VEC[i].pulse;
            ext_pd_in    = VEC[i].ext;
            @(negedge clk);
            idle();
            check($sformatf("vector %0d (R2-table)", i), {pd_out, wake_flag, irq_out},
                  {VEC[i].pd, VEC[i].flag, VEC[i].irq});
        end
        // R5: combinational path from ext with no clock edge.
        ext_pd_in = 1'b1; #1;
        check("R5 ext direct", {pd_out, wake_flag, irq_out}, 3'b100);
        ext_pd_in = 1'b0;
        // Build up state: request, aux, irq enable, flag.
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = 4'd1; host_wr_data = 2'b11; @(negedge clk);
        host_wr_addr = 4'd0; host_wr_data = 2'b11; @(negedge clk);
        idle(); wake_pulse = 1'b1; @(negedge clk);
        idle();
        host_wr_en = 1'b1; host_wr_addr = 4'd0; host_wr_data = 2'b11; @(negedge clk);
        idle();
        check("R1 pre-reset setup", {pd_out, wake_flag, irq_out}, 3'b111);
        // R1: reset mid-run clears everything.
        rst_n = 1'b0; @(negedge clk);
        check("R1 reset clears", {pd_out, wake_flag, irq_out}, 3'b000);
        ext_pd_in = 1'b1; #1;
        check("R1 pd follows ext in reset", {pd_out, wake_flag, irq_out}, 3'b100);
        ext_pd_in = 1'b0;
        rst_n = 1'b1; @(negedge clk);
        // R1/R8: wake enable was cleared by reset, so a pulse does nothing.
        wake_pulse = 1'b1; @(negedge clk); idle();
        check("R1 R8 wake enable reset", {pd_out, wake_flag, irq_out}, 3'b000);
        // R4: aux bits survive a write to another offset.
        host_wr_en = 1'b1; host_wr_addr = 4'd1; host_wr_data = 2'b01; @(negedge clk);
        host_wr_addr = 4'd7; host_wr_data = 2'b10; @(negedge clk); idle();
        check("R4 aux kept", {pd_out, wake_flag, irq_out}, 3'b100);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule